// File: doc/BRIEF.md
# Register-Array Byte ALU Sequencer

This block runs one multi-byte arithmetic or logic instruction over two arrays of byte registers held in its own 128-entry register file. A three-byte instruction is offered with a start strobe. The first byte picks one of eight byte operations. The second byte carries a write-enable bit, an operand-swap bit and the first register of an array in the upper half of the file. The third byte gives the low index of the last register and the page of a partner array in the lower half. The engine then steps through both arrays together, one byte every four cycles, with the least significant byte first. It chains carry or borrow from each byte into the next.

When the instruction ends, the block raises a one-cycle completion pulse and presents a zero flag for the whole multi-byte result and a carry flag from the final byte. In check mode the same flags are produced, but no register changes. A host port reads and writes the register file while the engine is idle. Start time is modelled with a fixed set-up period, which is longer when the slow-bus input is set, plus four cycles per byte.

Top module: `regarray_alu_seq`

## Requirements
- R1: A start is taken only when the engine is idle, opcode bits 7:3 equal 00010 and descriptor bits 4:3 equal 00. Any other start leaves busy low and every register unchanged.
- R2: Opcode bits 2:0 select the operation: 0 NAND, 1 XOR, 2 BCD subtract, 3 binary subtract, 4 AND, 5 OR, 6 BCD add, 7 binary add.
- R3: Operand byte bits 5:3 and 2:0 give array A at address {1, bits 5:3, index}, starting at index bits 2:0. Descriptor bits 2:0 give the page of array B at {0, page, index}. Descriptor bits 7:5 give the last index. The index rises by one and wraps modulo 8 inside its page, so the instruction covers ((last − first) mod 8) + 1 bytes.
- R4: With operand byte bit 6 set, the result is A op B and is written to array A. With bit 6 clear, the result is B op A and is written to array B.
- R5: With operand byte bit 7 clear (check mode), no register changes, but the flags are still updated.
- R6: The first byte starts with carry or borrow of 0. Each later byte uses the carry or borrow out of the byte before it. The BCD variants treat each nibble as one decimal digit.
- R7: At completion, zero_o is 1 exactly when every result byte is zero. carry_o holds the carry or borrow out of the final byte for the four arithmetic operations and 0 for the logic operations. The flags change only in the cycle in which done_o is high.
- R8: After the accepting clock edge, busy_o stays high for 6 + 4n cycles when slow_i is 0, or 9 + 4n cycles when slow_i is 1. In the next cycle done_o is high for exactly one cycle while busy_o is low.
- R9: host_rdata_o shows the register at host_addr_i without a clock delay. A host write takes effect only while idle. Host writes and new starts offered while busy are dropped.
- R10: After reset, busy_o, done_o, zero_o and carry_o are 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Instruction start strobe |
| opcode_i | input | 8 | Instruction byte 1: operation |
| dst_i | input | 8 | Instruction byte 2: write, swap, array A start |
| desc_i | input | 8 | Instruction byte 3: last index, page of array B |
| slow_i | input | 1 | Selects the longer set-up period |
| host_we_i | input | 1 | Host register write strobe |
| host_addr_i | input | 7 | Host register address |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| zero_o | output | 1 | Whole result is zero |
| carry_o | output | 1 | Carry or borrow out of final byte |

## Verification
Two events can land on the same clock edge: the engine's write-back of a result byte and a host write to that same register. The bench raises the host write strobe in the exact busy cycle whose closing edge stores the first result byte, aimed at that byte's address. It then expects the register to hold the engine's value, not the host's. A second start strobe is also fired into the middle of a run. That case is judged by an unchanged busy length and by results that match only the first instruction.

// File: rtl/regarray_alu_pkg.sv
package regarray_alu_pkg;

    localparam int DW = 8;
    localparam int NW = 4;

    typedef enum logic [2:0] {
        OP_NAND = 3'd0,
        OP_XOR  = 3'd1,
        OP_BSUB = 3'd2,
        OP_SUB  = 3'd3,
        OP_AND  = 3'd4,
        OP_OR   = 3'd5,
        OP_BADD = 3'd6,
        OP_ADD  = 3'd7
    } aop_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_STEP = 2'd2
    } seq_st_e;

endpackage

// File: rtl/ar_decode.sv
module ar_decode
    import regarray_alu_pkg::*;
#(
    parameter logic [4:0] OPC_GROUP = 5'b00010
) (
    input  logic [7:0] opcode_i,
    input  logic [7:0] dst_i,
    input  logic [7:0] desc_i,
    output logic       legal_o,
    output logic       wr_o,
    output logic       swap_o,
    output aop_e       op_o,
    output logic [2:0] first_o,
    output logic [2:0] ahi_o,
    output logic [2:0] bpage_o,
    output logic [3:0] nbytes_o
);
    logic [2:0] span;

    always_comb begin
        legal_o  = (opcode_i[7:3] == OPC_GROUP) && (desc_i[4:3] == 2'b00);
        op_o     = aop_e'(opcode_i[2:0]);
        wr_o     = dst_i[7];
        swap_o   = dst_i[6];
        ahi_o    = dst_i[5:3];
        first_o  = dst_i[2:0];
        bpage_o  = desc_i[2:0];
        span     = desc_i[7:5] - dst_i[2:0];
        nbytes_o = {1'b0, span} + 4'd1;
    end
endmodule

// File: rtl/ar_byte_alu.sv
module ar_byte_alu
    import regarray_alu_pkg::*;
(
    input  aop_e          op_i,
    input  logic [DW-1:0] x_i,
    input  logic [DW-1:0] y_i,
    input  logic          cin_i,
    output logic [DW-1:0] res_o,
    output logic          cout_o
);
    localparam int DIGITS = DW / NW;

    logic [NW:0] dsum;
    logic        dcy;

    always_comb begin
        res_o  = '0;
        cout_o = 1'b0;
        dsum   = '0;
        dcy    = cin_i;
        case (op_i)
            OP_NAND: res_o = ~(x_i & y_i);
            OP_XOR:  res_o = x_i ^ y_i;
            OP_AND:  res_o = x_i & y_i;
            OP_OR:   res_o = x_i | y_i;
            OP_ADD:  {cout_o, res_o} = {1'b0, x_i} + {1'b0, y_i} + (DW+1)'(cin_i);
            OP_SUB:  {cout_o, res_o} = {1'b0, x_i} - {1'b0, y_i} - (DW+1)'(cin_i);
            OP_BADD: begin
                for (int d = 0; d < DIGITS; d++) begin
                    dsum = {1'b0, x_i[d*NW +: NW]} + {1'b0, y_i[d*NW +: NW]} + (NW+1)'(dcy);
                    if (dsum > (NW+1)'(9)) begin
                        dsum = dsum + (NW+1)'(6);
                        dcy  = 1'b1;
                    end else begin
                        dcy  = 1'b0;
                    end
                    res_o[d*NW +: NW] = dsum[NW-1:0];
                end
                cout_o = dcy;
            end
            OP_BSUB: begin
                for (int d = 0; d < DIGITS; d++) begin
                    dsum = {1'b0, x_i[d*NW +: NW]} - {1'b0, y_i[d*NW +: NW]} - (NW+1)'(dcy);
                    if (dsum[NW]) begin
                        dsum = dsum - (NW+1)'(6);
                        dcy  = 1'b1;
                    end else begin
                        dcy  = 1'b0;
                    end
                    res_o[d*NW +: NW] = dsum[NW-1:0];
                end
                cout_o = dcy;
            end
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/ar_regfile.sv
module ar_regfile
    import regarray_alu_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          host_we_i,
    input  logic [AW-1:0] host_addr_i,
    input  logic [DW-1:0] host_wdata_i,
    output logic [DW-1:0] host_rdata_o,
    input  logic          eng_we_i,
    input  logic [AW-1:0] eng_waddr_i,
    input  logic [DW-1:0] eng_wdata_i,
    input  logic [AW-1:0] rd_a_addr_i,
    output logic [DW-1:0] rd_a_data_o,
    input  logic [AW-1:0] rd_b_addr_i,
    output logic [DW-1:0] rd_b_data_o
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (eng_we_i) begin
            mem_q[eng_waddr_i] <= eng_wdata_i;
        end else if (host_we_i) begin
            mem_q[host_addr_i] <= host_wdata_i;
        end
    end

    assign host_rdata_o = mem_q[host_addr_i];
    assign rd_a_data_o  = mem_q[rd_a_addr_i];
    assign rd_b_data_o  = mem_q[rd_b_addr_i];
endmodule

// File: rtl/regarray_alu_seq.sv
module regarray_alu_seq
    import regarray_alu_pkg::*;
#(
    parameter int REGS     = 128,
    parameter int OVH_FAST = 6,
    parameter int OVH_SLOW = 9,
    parameter int STEP_CYC = 4
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       start_i,
    input  logic [7:0] opcode_i,
    input  logic [7:0] dst_i,
    input  logic [7:0] desc_i,
    input  logic       slow_i,
    input  logic       host_we_i,
    input  logic [6:0] host_addr_i,
    input  logic [7:0] host_wdata_i,
    output logic [7:0] host_rdata_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       zero_o,
    output logic       carry_o
);
    localparam int AW = $clog2(REGS);
    localparam int PW = $clog2(OVH_SLOW + 1);
    localparam int SW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam logic [SW-1:0] SUB_LAST = SW'(STEP_CYC - 1);

    typedef struct packed {
        seq_st_e     st;
        logic [PW-1:0] pre;
        logic [SW-1:0] sub;
        logic [2:0]  idx;
        logic [3:0]  left;
        logic        wr;
        logic        swap;
        aop_e        op;
        logic [2:0]  ahi;
        logic [2:0]  bpage;
        logic        cy;
        logic        zacc;
        logic        done;
        logic        zf;
        logic        cf;
    } seq_s;

    seq_s q, d;

    logic          dec_legal, dec_wr, dec_swap;
    aop_e          dec_op;
    logic [2:0]    dec_first, dec_ahi, dec_bpage;
    logic [3:0]    dec_n;
    logic [AW-1:0] a_addr, b_addr, w_addr;
    logic [DW-1:0] a_data, b_data, x_opnd, y_opnd, alu_res;
    logic          alu_cout, eng_we, host_we_ok, res_zero;

    ar_decode u_dec (
        .opcode_i (opcode_i),
        .dst_i    (dst_i),
        .desc_i   (desc_i),
        .legal_o  (dec_legal),
        .wr_o     (dec_wr),
        .swap_o   (dec_swap),
        .op_o     (dec_op),
        .first_o  (dec_first),
        .ahi_o    (dec_ahi),
        .bpage_o  (dec_bpage),
        .nbytes_o (dec_n)
    );

    always_comb begin
        a_addr = AW'({1'b1, q.ahi, q.idx});
        b_addr = AW'({1'b0, q.bpage, q.idx});
        x_opnd = q.swap ? a_data : b_data;
        y_opnd = q.swap ? b_data : a_data;
        w_addr = q.swap ? a_addr : b_addr;
        host_we_ok = host_we_i && (q.st == ST_IDLE);
    end

    ar_regfile #(.DEPTH(REGS), .AW(AW)) u_rf (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .host_we_i    (host_we_ok),
        .host_addr_i  (host_addr_i),
        .host_wdata_i (host_wdata_i),
        .host_rdata_o (host_rdata_o),
        .eng_we_i     (eng_we),
        .eng_waddr_i  (w_addr),
        .eng_wdata_i  (alu_res),
        .rd_a_addr_i  (a_addr),
        .rd_a_data_o  (a_data),
        .rd_b_addr_i  (b_addr),
        .rd_b_data_o  (b_data)
    );

    ar_byte_alu u_alu (
        .op_i   (q.op),
        .x_i    (x_opnd),
        .y_i    (y_opnd),
        .cin_i  (q.cy),
        .res_o  (alu_res),
        .cout_o (alu_cout)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        eng_we   = 1'b0;
        res_zero = (alu_res == '0);
        case (q.st)
            ST_IDLE: begin
                if (start_i && dec_legal) begin
                    d.st    = ST_PRE;
                    d.pre   = slow_i ? PW'(OVH_SLOW - 1) : PW'(OVH_FAST - 1);
                    d.sub   = '0;
                    d.idx   = dec_first;
                    d.left  = dec_n;
                    d.wr    = dec_wr;
                    d.swap  = dec_swap;
                    d.op    = dec_op;
                    d.ahi   = dec_ahi;
                    d.bpage = dec_bpage;
                    d.cy    = 1'b0;
                    d.zacc  = 1'b1;
                end
            end
            ST_PRE: begin
                if (q.pre == '0) d.st  = ST_STEP;
                else             d.pre = q.pre - PW'(1);
            end
            ST_STEP: begin
                d.sub = q.sub + SW'(1);
                if (q.sub == SUB_LAST) begin
                    d.sub  = '0;
                    eng_we = q.wr;
                    d.cy   = alu_cout;
                    d.zacc = q.zacc & res_zero;
                    d.idx  = q.idx + 3'd1;
                    d.left = q.left - 4'd1;
                    if (q.left == 4'd1) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.zf   = q.zacc & res_zero;
                        d.cf   = alu_cout;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.op    <= OP_NAND;
        end else begin
            q <= d;
        end
    end

    assign busy_o  = (q.st != ST_IDLE);
    assign done_o  = q.done;
    assign zero_o  = q.zf;
    assign carry_o = q.cf;
endmodule

// File: rtl/regarray_alu_seq_chk.sv
module regarray_alu_seq_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic zero_o,
    input logic carry_o
);
    // R8: completion pulse only while idle
    p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    // R8: completion only directly after a busy cycle
    p_done_after_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $past(busy_o));

    // R8: completion lasts one cycle
    p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R7: flags move only with the completion pulse
    p_flags_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable({zero_o, carry_o}));

    // R1: a run begins only after a start strobe
    p_run_needs_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(start_i));
endmodule

bind regarray_alu_seq regarray_alu_seq_chk i_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .zero_o  (zero_o),
    .carry_o (carry_o)
);

// File: tb/test_regarray_alu_seq.sv
module test_regarray_alu_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] opcode = '0, dst = '0, desc = '0;
    logic       slow = 1'b0;
    logic       host_we = 1'b0;
    logic [6:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       busy, done, zero, carry;

    int checks = 0;
    int errors = 0;
    logic [7:0] shadow [128];

    always #5ns clk = ~clk;

    regarray_alu_seq i_regarray_alu_seq (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode),
        .dst_i(dst), .desc_i(desc), .slow_i(slow), .host_we_i(host_we),
        .host_addr_i(host_addr), .host_wdata_i(host_wdata),
        .host_rdata_o(host_rdata), .busy_o(busy), .done_o(done),
        .zero_o(zero), .carry_o(carry)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary_and_end();
    end

    task automatic host_write(input logic [6:0] a, input logic [7:0] v);
        @(negedge clk);
        host_addr = a; host_wdata = v; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
        shadow[a] = v;
    endtask

    // R9 / R5: compare every register with the bench copy, one check
    task automatic check_regs(input string tag);
        int bad = -1;
        logic [7:0] got = '0;
        for (int a = 0; a < 128; a++) begin
            host_addr = 7'(a);
            #1ns;
            if (bad < 0 && host_rdata !== shadow[a]) begin
                bad = a; got = host_rdata;
            end
        end
        if (bad < 0) chk(1'b1, tag, "registers", 0, 0);
        else chk(1'b0, tag, $sformatf("register %0h", bad), got, shadow[bad]);
    endtask

    function automatic longint unsigned pow10(input int e);
        longint unsigned p = 1;
        for (int i = 0; i < e; i++) p = p * 10;
        return p;
    endfunction

    function automatic longint unsigned bcd2dec(input logic [63:0] v, input int nd);
        longint unsigned r = 0;
        for (int i = nd - 1; i >= 0; i--) r = r * 10 + longint'(v[i*4 +: 4]);
        return r;
    endfunction

    function automatic logic [63:0] dec2bcd(input longint unsigned v, input int nd);
        logic [63:0] r = '0;
        for (int i = 0; i < nd; i++) begin
            r[i*4 +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

    // R2 / R6: whole-array expected result from integer arithmetic
    function automatic void model(input logic [2:0] op, input logic [63:0] x,
                                  input logic [63:0] y, input int n,
                                  output logic [63:0] r, output bit cy);
        logic [63:0] mask;
        logic [64:0] t;
        longint unsigned dx, dy, lim;
        mask = (n == 8) ? '1 : ((64'd1 << (8*n)) - 64'd1);
        lim  = pow10(2*n);
        cy = 1'b0;
        case (op)
            3'd0: r = ~(x & y) & mask;
            3'd1: r = (x ^ y) & mask;
            3'd4: r = x & y;
            3'd5: r = x | y;
            3'd7: begin
                t = {1'b0, x} + {1'b0, y};
                cy = t[8*n];
                r = t[63:0] & mask;
            end
            3'd3: begin
                cy = (x < y);
                r = (x - y) & mask;
            end
            3'd6: begin
                dx = bcd2dec(x, 2*n); dy = bcd2dec(y, 2*n);
                dx = dx + dy;
                cy = (dx >= lim);
                if (cy) dx = dx - lim;
                r = dec2bcd(dx, 2*n);
            end
            default: begin
                dx = bcd2dec(x, 2*n); dy = bcd2dec(y, 2*n);
                cy = (dx < dy);
                r = cy ? dec2bcd(dx + lim - dy, 2*n) : dec2bcd(dx - dy, 2*n);
            end
        endcase
    endfunction

    function automatic logic [7:0] rand_byte(input bit bcd);
        logic [7:0] v = 8'($urandom);
        if (bcd) v = {4'($urandom % 10), 4'($urandom % 10)};
        return v;
    endfunction

    task automatic preload(input logic [7:0] a1, input logic [7:0] a2, input bit bcd);
        int n = int'(3'(a2[7:5] - a1[2:0])) + 1;
        for (int k = 0; k < n; k++) begin
            host_write({1'b1, a1[5:3], 3'(a1[2:0] + k)}, rand_byte(bcd));
            host_write({1'b0, a2[2:0], 3'(a1[2:0] + k)}, rand_byte(bcd));
        end
    endtask

    // Runs one instruction and checks timing (R8), flags (R7), results.
    task automatic run_instr(input logic [7:0] opc, input logic [7:0] a1,
                             input logic [7:0] a2, input bit slw,
                             input int inj_start_at, input int inj_wr_at);
        int n = int'(3'(a2[7:5] - a1[2:0])) + 1;
        int exp_cyc = (slw ? 9 : 6) + 4 * n;
        int cnt = 0;
        logic [63:0] av = '0, bv = '0, xv, yv, rv;
        bit cy, zf;
        logic [6:0] aad [8];
        logic [6:0] bad [8];
        logic [6:0] wad0;
        for (int k = 0; k < n; k++) begin
            aad[k] = {1'b1, a1[5:3], 3'(a1[2:0] + k)};
            bad[k] = {1'b0, a2[2:0], 3'(a1[2:0] + k)};
            av[k*8 +: 8] = shadow[aad[k]];
            bv[k*8 +: 8] = shadow[bad[k]];
        end
        xv = a1[6] ? av : bv;
        yv = a1[6] ? bv : av;
        model(opc[2:0], xv, yv, n, rv, cy);
        zf = (rv == '0);
        wad0 = a1[6] ? aad[0] : bad[0];
        @(negedge clk);
        opcode = opc; dst = a1; desc = a2; slow = slw; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy && cnt < 400) begin
            cnt++;
            start = 1'b0;
            host_we = 1'b0;
            if (cnt == inj_start_at) begin
                opcode = 8'h17; dst = 8'hFF; desc = 8'h00; slow = ~slw; start = 1'b1;
            end
            if (cnt == inj_wr_at) begin
                host_addr = wad0; host_wdata = 8'hA5; host_we = 1'b1;
            end
            @(negedge clk);
        end
        start = 1'b0;
        host_we = 1'b0;
        chk(cnt == exp_cyc, "R8", "busy cycles", cnt, exp_cyc);
        chk(done === 1'b1, "R8", "done after busy", done, 1);
        chk(zero === zf, "R7", "zero flag", zero, zf);
        chk(carry === cy, "R6/R7", "carry flag", carry, cy);
        @(negedge clk);
        chk(done === 1'b0, "R8", "done one cycle", done, 0);
        if (a1[7]) begin
            for (int k = 0; k < n; k++) begin
                if (a1[6]) shadow[aad[k]] = rv[k*8 +: 8];
                else       shadow[bad[k]] = rv[k*8 +: 8];
            end
        end
        check_regs(a1[7] ? "R2/R3/R4 result" : "R5 check mode");
    endtask

    initial begin
        void'($urandom(32'h5eed));
        for (int a = 0; a < 128; a++) shadow[a] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(busy === 1'b0 && done === 1'b0, "R10", "busy/done", {busy, done}, 0);
        chk(zero === 1'b0 && carry === 1'b0, "R10", "flags", {zero, carry}, 0);
        check_regs("R10 reset contents");

        // R9: idle host write then read
        host_write(7'h45, 8'h3C);
        host_write(7'h05, 8'hC3);
        check_regs("R9 host write");

        // R1: wrong opcode group, then reserved descriptor bits
        @(negedge clk);
        opcode = 8'h18; dst = 8'hC0; desc = 8'hE0; start = 1'b1;
        @(negedge clk);
        opcode = 8'h17; desc = 8'hE8;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R1", "rejected start", busy, 0);
        check_regs("R1 no change");

        // R6: BCD add ripple 9999 + 0001, result written to A (swap=1)
        host_write(7'h40, 8'h99); host_write(7'h41, 8'h99);
        host_write(7'h00, 8'h01); host_write(7'h01, 8'h00);
        run_instr(8'h16, 8'hC0, 8'h20, 1'b0, 0, 0);

        // R6: binary subtract 0x0100 - 0x0001 into B (swap=0): B - A
        host_write(7'h40, 8'h01); host_write(7'h41, 8'h00);
        host_write(7'h00, 8'h00); host_write(7'h01, 8'h01);
        run_instr(8'h13, 8'h80, 8'h20, 1'b1, 0, 0);

        // R3: index wraps inside the page (start 6, last 1, four bytes)
        preload(8'hDE, 8'h23, 1'b0);
        run_instr(8'h17, 8'hDE, 8'h23, 1'b0, 0, 0);

        // R3: full eight bytes and a single byte
        preload(8'hF8, 8'hE5, 1'b0);
        run_instr(8'h11, 8'hF8, 8'hE5, 1'b1, 0, 0);
        preload(8'hCB, 8'h66, 1'b0);
        run_instr(8'h10, 8'hCB, 8'h66, 1'b0, 0, 0);

        // R5: check mode leaves registers, flags still follow
        preload(8'h40, 8'h41, 1'b1);
        run_instr(8'h12, 8'h40, 8'h41, 1'b0, 0, 0);

        // R9: host write on the first write-back edge, start while busy
        preload(8'hC0, 8'h60, 1'b0);
        run_instr(8'h17, 8'hC0, 8'h60, 1'b0, 2, 10);
        preload(8'h88, 8'h62, 1'b0);
        run_instr(8'h15, 8'h88, 8'h62, 1'b1, 3, 13);

        // Random mix of operations, modes, arrays and bus speed
        for (int t = 0; t < 60; t++) begin
            logic [2:0] op = 3'($urandom);
            logic [7:0] a1 = 8'($urandom);
            logic [7:0] a2 = {3'($urandom), 2'b00, 3'($urandom)};
            bit bcd = (op == 3'd2) || (op == 3'd6);
            preload(a1, a2, bcd);
            run_instr({5'b00010, op}, a1, a2, 1'($urandom), 0, 0);
        end

        summary_and_end();
    end
endmodule